// File: doc/BRIEF.md
# Windowed Watchdog Timer

This block is a watchdog that counts a slow time-base strobe (nominally about 1 kHz) while software keeps it alive by writing a key byte to a kick register. If no valid kick arrives within the programmed period, the block emits a one-cycle reset request towards the system reset controller. An early-warning flag, optionally routed to an interrupt line, can be raised part-way through the period. In window mode a kick is only legal once a closed window has elapsed since the last restart; an early kick or a kick with the wrong key triggers the reset request at once.

Periods, window length and warning point all use one power-of-two encoding: code n means 8 << n ticks. The block sits on a small byte-wide register port in the register clock domain. The slow tick arrives as a single-cycle strobe `tick_en` synchronous to that clock. Writes that the counting side must see (control, timing configuration, accepted kicks) are held pending until the next tick strobe, and a busy status bit shows that they are still in flight. The timing settings are frozen while the watchdog is requested or running.

Register map (3-bit address, 8-bit data): 0 control (bit0 run, bit1 window mode), 1 timing (bits 3:0 period code, bits 7:4 window code), 2 warning code (bits 3:0), 3 interrupt-enable set (write bit0 = 1), 4 interrupt-enable clear (write bit0 = 1), 5 warning flag (bit0, write 1 to clear), 6 kick (write only, reads 0), 7 status (bit0 busy). Registers 3 and 4 both read back the interrupt enable in bit0.

Top module: `wwdt_top`

## Requirements
- R1: After reset every register reads 0, and `irq` and `rst_req` are 0.
- R2: A write to control, an unlocked write to timing, or an accepted kick sets status bit0; it clears at the first tick strobe after the write's clock edge, and the written setting takes effect at that same edge.
- R3: Running in normal mode without kicks, `rst_req` pulses for exactly one clock at the tick edge that is 8 << period-code ticks after the tick that started the count; the count then restarts and the pulse repeats with the same spacing.
- R4: Codes written above their limit are stored saturated: period and warning codes at 11 (16384 ticks), window code at 10 (8192 ticks); timing reads back as {window code, period code}.
- R5: While control bit0 is 1 or the counter is running, writes to timing and warning are ignored and control bit1 keeps its value.
- R6: The warning flag (register 5 bit0) is set at the tick edge where the count reaches 8 << warning-code; `irq` is the flag ANDed with the interrupt enable; writing 1 to bit0 of register 5 clears the flag.
- R7: A kick of 0xA5 accepted while running in normal mode restarts the count at the next tick, so the next timeout comes 8 << period-code ticks after that tick.
- R8: A kick of any other value while running and not busy raises `rst_req` one clock after the write edge.
- R9: In window mode a 0xA5 kick while the count is below 8 << window-code raises `rst_req` one clock after the write; a 0xA5 kick at or beyond that point restarts the count like R7.
- R10: While stopped, the count is held at zero, kicks have no effect and `rst_req` stays 0.
- R11: A kick written while status bit0 is 1 is ignored: it neither raises `rst_req` nor changes the pending restart.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Register clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_en | input | 1 | One-cycle slow time-base strobe |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Register address for read and write |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data of the addressed register (combinational) |
| irq | output | 1 | Early-warning interrupt (level) |
| rst_req | output | 1 | One-cycle reset request |

## Verification
A bad kick shows on `rst_req` one clock after its write edge, so the bench drives the write on a falling edge and looks at `rst_req` on the falling edge right after the write edge, then again one clock later for the pulse end. Timeouts, warning flags, restarts and busy release all land on tick edges, so the bench counts tick strobes itself and measures every interval in ticks from the tick that cleared busy, sampling on falling edges. Where a tick could race a write (pending kick, bad kick), the bench suspends its own tick strobe so the expected cycle is fixed.

// File: rtl/wwdt_pkg.sv
package wwdt_pkg;
  localparam int BASE_LOG2 = 3;
  localparam int MAX_PER   = 11;
  localparam int MAX_WIN   = 10;
  localparam int CODE_W    = 4;
  localparam int DATA_W    = 8;
  localparam int ADDR_W    = 3;
  localparam logic [7:0] KICK_KEY = 8'hA5;

  typedef enum logic [ADDR_W-1:0] {
    A_CTRL    = 3'd0,
    A_TIMING  = 3'd1,
    A_WARN    = 3'd2,
    A_IEN_SET = 3'd3,
    A_IEN_CLR = 3'd4,
    A_FLAG    = 3'd5,
    A_KICK    = 3'd6,
    A_STAT    = 3'd7
  } reg_addr_e;

  function automatic logic [CODE_W-1:0] sat_code(input logic [CODE_W-1:0] c,
                                                 input int unsigned lim);
    return (32'(c) > lim) ? CODE_W'(lim) : c;
  endfunction
endpackage

// File: rtl/wwdt_regs.sv
module wwdt_regs
  import wwdt_pkg::*;
#(
  parameter int CW   = CODE_W,
  parameter int DW   = DATA_W,
  parameter int AW   = ADDR_W,
  parameter int PMAX = MAX_PER,
  parameter int WMAX = MAX_WIN
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick_en,
  input  logic          wr_en,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  input  logic          core_en,
  input  logic          clr_busy,
  input  logic          ew_set,
  output logic [DW-1:0] rdata,
  output logic          run_sh,
  output logic          win_sh,
  output logic [CW-1:0] per_code,
  output logic [CW-1:0] win_code,
  output logic [CW-1:0] ew_code,
  output logic          apply_ctrl,
  output logic          kick_wr,
  output logic          flag,
  output logic          irq,
  output logic          busy,
  output logic          lock
);
  logic pend_ctrl, pend_cfg, ien;
  logic wr_ctrl, wr_timing, wr_warn;

  assign lock       = run_sh | core_en;
  assign busy       = pend_ctrl | pend_cfg | clr_busy;
  assign wr_ctrl    = wr_en && (addr == A_CTRL);
  assign wr_timing  = wr_en && (addr == A_TIMING) && !lock;
  assign wr_warn    = wr_en && (addr == A_WARN) && !lock;
  assign kick_wr    = wr_en && (addr == A_KICK) && !busy;
  assign apply_ctrl = pend_ctrl & tick_en;
  assign irq        = flag & ien;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_sh    <= 1'b0;
      win_sh    <= 1'b0;
      per_code  <= '0;
      win_code  <= '0;
      ew_code   <= '0;
      pend_ctrl <= 1'b0;
      pend_cfg  <= 1'b0;
      ien       <= 1'b0;
      flag      <= 1'b0;
    end else begin
      if (wr_ctrl) begin
        run_sh    <= wdata[0];
        if (!lock) win_sh <= wdata[1];
        pend_ctrl <= 1'b1;
      end else if (tick_en) begin
        pend_ctrl <= 1'b0;
      end
      if (wr_timing) begin
        per_code <= sat_code(wdata[CW-1:0], PMAX);
        win_code <= sat_code(wdata[2*CW-1:CW], WMAX);
        pend_cfg <= 1'b1;
      end else if (tick_en) begin
        pend_cfg <= 1'b0;
      end
      if (wr_warn) ew_code <= sat_code(wdata[CW-1:0], PMAX);
      if (wr_en && addr == A_IEN_SET && wdata[0]) ien <= 1'b1;
      else if (wr_en && addr == A_IEN_CLR && wdata[0]) ien <= 1'b0;
      if (ew_set) flag <= 1'b1;
      else if (wr_en && addr == A_FLAG && wdata[0]) flag <= 1'b0;
    end
  end

  always_comb begin
    rdata = '0;
    case (reg_addr_e'(addr))
      A_CTRL:    rdata = DW'({win_sh, run_sh});
      A_TIMING:  rdata = DW'({win_code, per_code});
      A_WARN:    rdata = DW'(ew_code);
      A_IEN_SET,
      A_IEN_CLR: rdata = DW'(ien);
      A_FLAG:    rdata = DW'(flag);
      A_STAT:    rdata = DW'(busy);
      default:   rdata = '0;
    endcase
  end
endmodule

// File: rtl/wwdt_core.sv
module wwdt_core
  import wwdt_pkg::*;
#(
  parameter int CW    = CODE_W,
  parameter int DW    = DATA_W,
  parameter int BASE  = BASE_LOG2,
  parameter int PMAX  = MAX_PER,
  parameter logic [DW-1:0] KEY = KICK_KEY,
  localparam int CNT_W = BASE + PMAX + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_en,
  input  logic             apply_ctrl,
  input  logic             run_sh,
  input  logic             win_sh,
  input  logic [CW-1:0]    per_code,
  input  logic [CW-1:0]    win_code,
  input  logic [CW-1:0]    ew_code,
  input  logic             kick_wr,
  input  logic [DW-1:0]    kick_data,
  output logic             core_en,
  output logic [CNT_W-1:0] cnt,
  output logic [CNT_W-1:0] per_ticks,
  output logic             ew_set,
  output logic             clr_busy,
  output logic             rst_req
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic             win_on, run_step, stop_now, timeout;
  logic             kick_bad, kick_ok, early;
  logic [CNT_W-1:0] win_ticks, ew_ticks, nxt;

  assign per_ticks = ONE << (BASE + int'(per_code));
  assign win_ticks = ONE << (BASE + int'(win_code));
  assign ew_ticks  = ONE << (BASE + int'(ew_code));
  assign nxt       = cnt + ONE;

  assign stop_now = apply_ctrl && !run_sh;
  assign run_step = tick_en && core_en && !stop_now && !clr_busy;
  assign timeout  = run_step && (nxt == per_ticks);
  assign ew_set   = run_step && (nxt == ew_ticks);

  assign early    = win_on && (cnt < win_ticks);
  assign kick_bad = kick_wr && core_en && ((kick_data != KEY) || early);
  assign kick_ok  = kick_wr && core_en && !kick_bad;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      core_en  <= 1'b0;
      win_on   <= 1'b0;
      cnt      <= '0;
      clr_busy <= 1'b0;
      rst_req  <= 1'b0;
    end else begin
      rst_req <= kick_bad | timeout;
      if (kick_ok) clr_busy <= 1'b1;
      else if (tick_en) clr_busy <= 1'b0;
      if (tick_en) begin
        if (apply_ctrl && !(core_en && run_sh)) begin
          core_en <= run_sh;
          win_on  <= win_sh;
          cnt     <= '0;
        end else if (core_en) begin
          if (clr_busy || timeout) cnt <= '0;
          else                     cnt <= nxt;
        end
      end
    end
  end
endmodule

// File: rtl/wwdt_top.sv
module wwdt_top
  import wwdt_pkg::*;
#(
  parameter int CW    = CODE_W,
  parameter int DW    = DATA_W,
  parameter int AW    = ADDR_W,
  parameter int BASE  = BASE_LOG2,
  parameter int PMAX  = MAX_PER,
  parameter int WMAX  = MAX_WIN,
  parameter logic [DW-1:0] KEY = KICK_KEY,
  localparam int CNT_W = BASE + PMAX + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick_en,
  input  logic          wr_en,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  output logic          irq,
  output logic          rst_req
);
  logic             run_sh, win_sh, apply_ctrl, kick_wr, flag, busy, lock;
  logic             core_en, ew_set, clr_busy;
  logic [CW-1:0]    per_code, win_code, ew_code;
  logic [CNT_W-1:0] cnt, per_ticks;

  wwdt_regs #(.CW(CW), .DW(DW), .AW(AW), .PMAX(PMAX), .WMAX(WMAX)) u_regs (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .wr_en(wr_en), .addr(addr),
    .wdata(wdata), .core_en(core_en), .clr_busy(clr_busy), .ew_set(ew_set),
    .rdata(rdata), .run_sh(run_sh), .win_sh(win_sh), .per_code(per_code),
    .win_code(win_code), .ew_code(ew_code), .apply_ctrl(apply_ctrl),
    .kick_wr(kick_wr), .flag(flag), .irq(irq), .busy(busy), .lock(lock)
  );

  wwdt_core #(.CW(CW), .DW(DW), .BASE(BASE), .PMAX(PMAX), .KEY(KEY)) u_core (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .apply_ctrl(apply_ctrl),
    .run_sh(run_sh), .win_sh(win_sh), .per_code(per_code), .win_code(win_code),
    .ew_code(ew_code), .kick_wr(kick_wr), .kick_data(wdata), .core_en(core_en),
    .cnt(cnt), .per_ticks(per_ticks), .ew_set(ew_set), .clr_busy(clr_busy),
    .rst_req(rst_req)
  );
endmodule

// File: rtl/wwdt_top_chk.sv
module wwdt_top_chk #(
  parameter int CW    = 4,
  parameter int CNT_W = 15
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tick_en,
  input logic             core_en,
  input logic [CNT_W-1:0] cnt,
  input logic [CNT_W-1:0] per_ticks,
  input logic             busy,
  input logic             flag,
  input logic             lock,
  input logic [CW-1:0]    per_code,
  input logic [CW-1:0]    win_code,
  input logic [CW-1:0]    ew_code,
  input logic             kick_wr,
  input logic             rst_req
);
  // R10
  held_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !core_en |-> cnt == '0);
  // R3
  cnt_below_period_chk: assert property (@(posedge clk) disable iff (!rst_n)
    core_en |-> cnt < per_ticks);
  // R2
  busy_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> $past(tick_en));
  // R6
  flag_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag) |-> $past(tick_en));
  // R5
  cfg_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lock |=> $stable({per_code, win_code, ew_code}));
  // R8
  rst_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |-> ($past(tick_en) || $past(kick_wr)));
endmodule

bind wwdt_top wwdt_top_chk #(.CW(CW), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .core_en(core_en), .cnt(cnt),
  .per_ticks(per_ticks), .busy(busy), .flag(flag), .lock(lock),
  .per_code(per_code), .win_code(win_code), .ew_code(ew_code),
  .kick_wr(kick_wr), .rst_req(rst_req)
);

// File: tb/wwdt_top_test.sv
module wwdt_top_test;
  localparam int TDIV = 4;
  localparam int LIMIT = 190000;

  logic clk = 1'b0, rst_n = 1'b0, tick_en = 1'b0, wr_en = 1'b0;
  logic [2:0] addr = '0;
  logic [7:0] wdata = '0, rdata;
  logic irq, rst_req;

  int checks = 0, fails = 0;
  int tick_cnt = 0, rst_seen = 0, last_rst_tick = 0, width_err = 0;
  int div = 0;
  bit pause = 1'b0, prev_rst = 1'b0, done = 1'b0;

  wwdt_top uut (.clk(clk), .rst_n(rst_n), .tick_en(tick_en), .wr_en(wr_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .irq(irq), .rst_req(rst_req));

  always #2 clk = ~clk;

  always @(negedge clk) begin
    div = (div == TDIV-1) ? 0 : div + 1;
    tick_en = rst_n && !pause && (div == 0);
  end

  always @(posedge clk) if (tick_en) tick_cnt <= tick_cnt + 1;

  always @(negedge clk) begin
    if (rst_req) begin
      rst_seen = rst_seen + 1;
      last_rst_tick = tick_cnt;
      if (prev_rst) width_err = width_err + 1;
    end
    prev_rst = rst_req;
  end

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (LIMIT) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: run hung, actual %0d cycles expected < %0d", LIMIT, LIMIT);
    finish_run();
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output int v);
    addr = a;
    #1 v = int'(rdata);
  endtask

  task automatic wait_idle();
    int v;
    for (int i = 0; i < 100; i++) begin
      rd(3'd7, v);
      if (v == 0) break;
      @(negedge clk);
    end
  endtask

  task automatic wait_ticks(input int n);
    int target = tick_cnt + n;
    while (tick_cnt < target) @(negedge clk);
  endtask

  task automatic wait_rst(input int r0);
    for (int i = 0; i < 100000 && rst_seen <= r0; i++) @(negedge clk);
  endtask

  function automatic int period(input int code);
    return 8 << code;
  endfunction

  int v, t0, t1, r0, p;

  initial begin
    void'($urandom(32'h5eed_0042));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset state
    for (int a = 0; a < 8; a++) begin
      rd(3'(a), v);
      chk($sformatf("R1 reg%0d", a), v, 0);
    end
    chk("R1 irq", int'(irq), 0);
    chk("R1 rst_req", int'(rst_req), 0);

    // R4: saturation and field layout
    wr(3'd1, 8'hFF);
    rd(3'd7, v); chk("R2 busy after timing write", v, 1);
    rd(3'd1, v); chk("R4 timing saturated", v, 8'hAB);
    wr(3'd2, 8'h0F);
    rd(3'd2, v); chk("R4 warning saturated", v, 11);
    wait_idle();
    rd(3'd7, v); chk("R2 busy released", v, 0);

    // R3: random period codes, two timeouts each
    for (int it = 0; it < 4; it++) begin
      p = (it == 0) ? 0 : int'($urandom_range(1, 3));
      wr(3'd1, 8'(p));
      wait_idle();
      wr(3'd0, 8'h01);
      rd(3'd7, v); chk("R2 busy after enable", v, 1);
      wait_idle();
      t0 = tick_cnt; r0 = rst_seen;
      wait_rst(r0);
      chk("R3 first timeout ticks", last_rst_tick - t0, period(p));
      t1 = last_rst_tick; r0 = rst_seen;
      wait_rst(r0);
      chk("R3 repeat timeout ticks", last_rst_tick - t1, period(p));
      if (it == 1) begin
        // R5: frozen while running
        rd(3'd1, t1);
        wr(3'd1, 8'h33);
        rd(3'd1, v); chk("R5 timing locked", v, t1);
        wr(3'd2, 8'h01);
        rd(3'd2, v); chk("R5 warning locked", v, 11);
        wr(3'd0, 8'h03);
        rd(3'd0, v); chk("R5 window bit locked", v, 1);
        wait_idle();
      end
      wr(3'd0, 8'h00);
      wait_idle();
    end
    chk("R3 pulse width one cycle", width_err, 0);

    // R6: early warning
    wr(3'd1, 8'h03);
    wr(3'd2, 8'h02);
    wr(3'd3, 8'h01);
    wait_idle();
    wr(3'd0, 8'h01);
    wait_idle();
    t0 = tick_cnt;
    for (int i = 0; i < 2000 && !irq; i++) @(negedge clk);
    chk("R6 warning tick", tick_cnt - t0, 32);
    rd(3'd5, v); chk("R6 flag set", v, 1);
    wr(3'd5, 8'h01);
    rd(3'd5, v); chk("R6 flag cleared", v, 0);
    chk("R6 irq low after clear", int'(irq), 0);
    wr(3'd4, 8'h01);
    for (int i = 0; i < 2000; i++) begin
      rd(3'd5, v);
      if (v == 1) break;
      @(negedge clk);
    end
    chk("R6 flag set again", v, 1);
    chk("R6 irq masked", int'(irq), 0);
    wr(3'd5, 8'h01);
    wr(3'd0, 8'h00);
    wait_idle();

    // R7 and R11: key kick restarts, kick while busy ignored
    wr(3'd1, 8'h02);
    wait_idle();
    wr(3'd0, 8'h01);
    wait_idle();
    wait_ticks(20);
    pause = 1'b1;
    r0 = rst_seen;
    wr(3'd6, 8'hA5);
    rd(3'd7, v); chk("R2 busy after kick", v, 1);
    wr(3'd6, 8'h00);
    @(negedge clk);
    chk("R11 no reset on kick while busy", rst_seen - r0, 0);
    pause = 1'b0;
    wait_idle();
    t1 = tick_cnt; r0 = rst_seen;
    wait_rst(r0);
    chk("R7 timeout after kick", last_rst_tick - t1, 32);

    // R8: wrong key
    wait_ticks(3);
    pause = 1'b1;
    wr(3'd6, 8'(($urandom_range(0, 254) + 8'hA6) % 256));
    #1 chk("R8 reset on wrong key", int'(rst_req), 1);
    @(negedge clk);
    #1 chk("R8 reset pulse ends", int'(rst_req), 0);
    pause = 1'b0;
    wr(3'd0, 8'h00);
    wait_idle();

    // R9: window mode
    wr(3'd1, 8'h24);
    wait_idle();
    wr(3'd0, 8'h03);
    wait_idle();
    rd(3'd0, v); chk("R9 control window mode", v, 3);
    t0 = tick_cnt;
    wait_ticks(10);
    pause = 1'b1;
    wr(3'd6, 8'hA5);
    #1 chk("R9 early kick resets", int'(rst_req), 1);
    rd(3'd7, v); chk("R9 early kick not accepted", v, 0);
    pause = 1'b0;
    while (tick_cnt < t0 + 40) @(negedge clk);
    pause = 1'b1;
    r0 = rst_seen;
    wr(3'd6, 8'hA5);
    #1 chk("R9 late kick no reset", int'(rst_req), 0);
    pause = 1'b0;
    wait_idle();
    t1 = tick_cnt;
    wait_rst(r0);
    chk("R9 timeout after late kick", last_rst_tick - t1, 128);

    // R10: stopped
    wr(3'd0, 8'h00);
    wait_idle();
    r0 = rst_seen;
    wr(3'd6, 8'h00);
    wait_ticks(300);
    chk("R10 no reset while stopped", rst_seen - r0, 0);
    rd(3'd7, v); chk("R10 kick ignored while stopped", v, 0);

    finish_run();
  end
endmodule